// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset requests into one timed recovery sequence: a power-on pulse, an overflow of an internal watchdog counter, and a digital flag that says the supply is still below its rising threshold. After a power-on or low-supply event, it keeps the module clocks gated while it counts a long oscillator settling delay on the reference clock. When that delay ends it releases the clocks. It then lets go of the active-low external reset pin at one offset and releases the CPU at a later offset.

A watchdog reset does not wait for the oscillator, because the oscillator is already running. It goes straight to the release phase, so the pin and the CPU are released at the same two offsets while the clocks stay enabled. Any bus write to the watchdog address clears the counter. The counter stays at zero whenever a reset sequence is in progress.

An 8-bit status register records why the last reset happened. A power-on event overwrites it. Low-supply and watchdog events add their bits to those already set. A status read returns the current value and clears the register on the next cycle.

Top module: `reset_sequencer`

## Requirements
- R1: After rst_ni is released, or on the edge after a power-on pulse, clk_en_o is low for exactly STAB_CYCLES (default 4096) reference-clock cycles.
- R2: rst_pin_no is low during the stabilization delay and goes high PIN_OFS (default 32) cycles after clk_en_o rises.
- R3: cpu_rel_o goes high CPU_OFS (default 64) cycles after clk_en_o rises, and never while rst_pin_no is low.
- R4: A power-on event sets status to 0x82: bit 7 (power-on) and bit 1 (low-supply), with every other bit cleared. This is also the value after rst_ni.
- R5: While lvi_low_i is high, rst_pin_no and clk_en_o are low and cpu_rel_o is low. The stabilization delay starts on the edge after lvi_low_i falls, and its timing follows R1 to R3.
- R6: A low-supply event sets status bit 1 and leaves the other set bits unchanged.
- R7: With the CPU released and no watchdog write, a watchdog reset occurs after 2^WDOG_W cycles, counted from the first cycle cpu_rel_o is high. It sets status bit 4 and leaves the other set bits unchanged.
- R8: A watchdog reset keeps clk_en_o high and drops rst_pin_no and cpu_rel_o at once. The pin is released after PIN_OFS cycles and the CPU after CPU_OFS cycles.
- R9: A watchdog write (wdog_wr_i) clears the counter. Writes spaced closer than 2^WDOG_W cycles keep cpu_rel_o high indefinitely.
- R10: A power-on pulse during any phase restarts the sequence at the start of the stabilization delay.
- R11: A status read (stat_rd_i) clears the register on the next cycle, unless a new event sets bits in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference (oscillator) clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| por_pulse_i | input | 1 | Power-on reset pulse |
| lvi_low_i | input | 1 | Supply below rising threshold |
| wdog_wr_i | input | 1 | Bus write to the watchdog control address |
| stat_rd_i | input | 1 | Bus read of the status register |
| clk_en_o | output | 1 | Enable for the CPU and module clocks |
| rst_pin_no | output | 1 | External reset pin drive, active low |
| cpu_rel_o | output | 1 | CPU released to fetch its reset vector |
| stat_o | output | 8 | Reset status (bit 7 power-on, bit 4 watchdog, bit 1 low-supply) |

## Verification
If the phase counter loses its place, the three release edges land at the wrong cycle. The bench counts every cycle from the triggering event, so an off-by-one shows at the first release after that event. A watchdog counter that is wrong shows up as a reset appearing or going missing within one watchdog period. If the status logic overwrites bits where it should accumulate them, or accumulates where it should overwrite, the mismatch appears on stat_o on the cycle after the event. Because status is not read between events, the bench sees each event's effect on the bits already set.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_STAB = 2'd1,
    PH_POST = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  localparam int unsigned ST_W       = 8;
  localparam int unsigned ST_POR_BIT = 7;
  localparam int unsigned ST_COP_BIT = 4;
  localparam int unsigned ST_LVI_BIT = 1;
  localparam logic [ST_W-1:0] ST_POR_VAL = ST_W'((1 << ST_POR_BIT) | (1 << ST_LVI_BIT));
endpackage

// File: rtl/rst_seq_wdog.sv
module rst_seq_wdog #(
  parameter int unsigned WDOG_W = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic ovf_o
);
  logic [WDOG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || kick_i)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = run_i && !kick_i && (&cnt_q);

  assert_kick_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == '0);
  assert_ovf_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0);
endmodule

// File: rtl/rst_seq_status.sv
module rst_seq_status
  import rst_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            por_i,
  input  logic            lvi_i,
  input  logic            cop_i,
  input  logic            rd_i,
  output logic [ST_W-1:0] stat_o
);
  logic [ST_W-1:0] stat_q, set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[ST_LVI_BIT] = lvi_i;
    set_mask[ST_COP_BIT] = cop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= ST_POR_VAL;
    else if (por_i)  stat_q <= ST_POR_VAL;
    else             stat_q <= (rd_i ? '0 : stat_q) | set_mask;
  end

  assign stat_o = stat_q;

  assert_por_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> stat_q == ST_POR_VAL);
  assert_cop_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_i && !por_i |=> stat_q[ST_COP_BIT]);
  assert_lvi_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvi_i |=> stat_q[ST_LVI_BIT]);
  assert_read_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !por_i && !lvi_i && !cop_i |=> stat_q == '0);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 4096,
  parameter int unsigned PIN_OFS     = 32,
  parameter int unsigned CPU_OFS     = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic lvi_i,
  input  logic wdog_ovf_i,
  output logic clk_en_o,
  output logic rst_pin_no,
  output logic cpu_rel_o,
  output logic run_o
);
  localparam int unsigned MAX_CNT = (STAB_CYCLES > CPU_OFS) ? STAB_CYCLES : CPU_OFS;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    if (por_i) begin
      phase_d = PH_STAB;
      cnt_d   = '0;
    end else if (lvi_i) begin
      phase_d = PH_LOW;
      cnt_d   = '0;
    end else if (wdog_ovf_i) begin
      phase_d = PH_POST;  // oscillator already stable
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_LOW: begin
          phase_d = PH_STAB;
          cnt_d   = '0;
        end
        PH_STAB: if (cnt_q == CNT_W'(STAB_CYCLES - 1)) begin
          phase_d = PH_POST;
          cnt_d   = '0;
        end
        PH_POST: if (cnt_q == CNT_W'(CPU_OFS - 1)) begin
          phase_d = PH_RUN;
          cnt_d   = '0;
        end
        PH_RUN: cnt_d = '0;
        default: begin
          phase_d = PH_STAB;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_STAB;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clk_en_o   = (phase_q == PH_POST) || (phase_q == PH_RUN);
  assign rst_pin_no = (phase_q == PH_RUN) ||
                      ((phase_q == PH_POST) && (cnt_q >= CNT_W'(PIN_OFS)));
  assign cpu_rel_o  = (phase_q == PH_RUN);
  assign run_o      = cpu_rel_o;

  assert_lvi_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvi_i && !por_i |=> !clk_en_o && !rst_pin_no && !cpu_rel_o);
  assert_por_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> phase_q == PH_STAB && cnt_q == '0);
  assert_wdog_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_ovf_i && !por_i && !lvi_i |=> clk_en_o && !rst_pin_no && !cpu_rel_o);
  assert_pin_before_cpu_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rel_o) |-> $past(rst_pin_no));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 4096,
  parameter int unsigned PIN_OFS     = 32,
  parameter int unsigned CPU_OFS     = 64,
  parameter int unsigned WDOG_W      = 18
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_pulse_i,
  input  logic       lvi_low_i,
  input  logic       wdog_wr_i,
  input  logic       stat_rd_i,
  output logic       clk_en_o,
  output logic       rst_pin_no,
  output logic       cpu_rel_o,
  output logic [7:0] stat_o
);
  logic run, wdog_ovf;

  rst_seq_fsm #(
    .STAB_CYCLES(STAB_CYCLES),
    .PIN_OFS    (PIN_OFS),
    .CPU_OFS    (CPU_OFS)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_i     (por_pulse_i),
    .lvi_i     (lvi_low_i),
    .wdog_ovf_i(wdog_ovf),
    .clk_en_o  (clk_en_o),
    .rst_pin_no(rst_pin_no),
    .cpu_rel_o (cpu_rel_o),
    .run_o     (run)
  );

  rst_seq_wdog #(.WDOG_W(WDOG_W)) i_wdog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .kick_i(wdog_wr_i),
    .ovf_o (wdog_ovf)
  );

  rst_seq_status i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .por_i (por_pulse_i),
    .lvi_i (lvi_low_i),
    .cop_i (wdog_ovf),
    .rd_i  (stat_rd_i),
    .stat_o(stat_o)
  );

  assert_release_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rel_o |-> rst_pin_no && clk_en_o);
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  localparam int STAB = 4096;
  localparam int PIN  = 32;
  localparam int CPU  = 64;
  localparam int WW   = 12;
  localparam int WP   = 1 << WW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por = 1'b0, lvi = 1'b0, kick = 1'b0, rd = 1'b0;
  logic clk_en, pin_n, cpu_rel;
  logic [7:0] stat;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  reset_sequencer #(.STAB_CYCLES(STAB), .PIN_OFS(PIN), .CPU_OFS(CPU), .WDOG_W(WW))
  i_reset_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .por_pulse_i(por), .lvi_low_i(lvi),
    .wdog_wr_i(kick), .stat_rd_i(rd), .clk_en_o(clk_en), .rst_pin_no(pin_n),
    .cpu_rel_o(cpu_rel), .stat_o(stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples at negedges; the current sample is index n0
  task automatic measure(input int n0, input int e_clk, input int e_pin, input int e_cpu,
                         input string req);
    int n = n0;
    int t_clk = -1, t_pin = -1, t_cpu = -1;
    while (t_cpu < 0 && n < n0 + 20000) begin
      if (clk_en && t_clk < 0) t_clk = n;
      if (pin_n && t_pin < 0) t_pin = n;
      if (cpu_rel && t_cpu < 0) t_cpu = n;
      if (t_cpu < 0) begin
        @(negedge clk);
        n++;
      end
    end
    check(t_clk == e_clk, {req, " R1 clk_en release"}, t_clk, e_clk);
    check(t_pin == e_pin, {req, " R2 pin release"}, t_pin, e_pin);
    check(t_cpu == e_cpu, {req, " R3 cpu release"}, t_cpu, e_cpu);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!clk_en && !pin_n && !cpu_rel, "R1 outputs in reset", {clk_en, pin_n, cpu_rel}, 0);
    check(stat == 8'h82, "R4 status after reset", stat, 8'h82);
    rst_ni = 1'b1;
    measure(0, STAB, STAB + PIN, STAB + CPU, "reset");
  endtask

  task automatic t_read();
    check(stat == 8'h82, "R4 status before read", stat, 8'h82);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(stat == 8'h00, "R11 status cleared by read", stat, 0);
  endtask

  task automatic t_kick();
    int bad = 0;
    for (int i = 0; i < 3 * WP; i++) begin
      kick = (i % 1000 == 0);
      @(negedge clk);
      if (!cpu_rel) bad++;
    end
    kick = 1'b0;
    check(bad == 0, "R9 kicks prevent watchdog reset", bad, 0);
  endtask

  task automatic t_lvi();
    int bad = 0;
    lvi = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (clk_en || pin_n || cpu_rel) bad++;
    end
    check(bad == 0, "R5 held while supply low", bad, 0);
    lvi = 1'b0;
    @(negedge clk);
    measure(1, STAB + 1, STAB + 1 + PIN, STAB + 1 + CPU, "R5 lvi");
    check(stat == 8'h02, "R6 low-supply status", stat, 8'h02);
  endtask

  task automatic t_wdog();
    int cnt = 0;
    int gated = 0;
    while (cpu_rel && cnt < 2 * WP) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == WP, "R7 watchdog period", cnt, WP);
    check(clk_en && !pin_n && !cpu_rel, "R8 watchdog entry state", {clk_en, pin_n, cpu_rel}, 4);
    for (int i = 0; i < 4; i++) begin
      if (!clk_en) gated++;
      @(negedge clk);
    end
    check(gated == 0, "R8 clocks stay enabled", gated, 0);
    measure(4, 4, PIN, CPU, "R8 watchdog");
    check(stat == 8'h12, "R7 watchdog status accumulates", stat, 8'h12);
  endtask

  task automatic t_por();
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    check(stat == 8'h82, "R4 power-on overwrites status", stat, 8'h82);
    repeat (STAB + PIN + 5) @(negedge clk);
    check(pin_n && !cpu_rel, "R10 mid-release before restart", {pin_n, cpu_rel}, 2);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    check(!clk_en && !pin_n, "R10 restart regates", {clk_en, pin_n}, 0);
    measure(1, STAB + 1, STAB + 1 + PIN, STAB + 1 + CPU, "R10 restart");
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_read();
    t_kick();
    t_lvi();
    t_wdog();
    t_por();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule